// File: doc/BRIEF.md
# Receive frame sequencing controller

This block runs the receive side of a contactless-card style link once the bits have been demodulated and decoded. A host arms it with a Receive command. After that, each start-of-frame strobe opens a frame. Incoming bits are packed least-significant-bit first into bytes, and each byte is pushed into an external receive FIFO as soon as it fills. At end-of-frame the block pushes any partial byte, zero-padded, and reports how many of its bits are valid. It then checks a CRC-16 that it accumulated bit by bit over the whole frame, updates a small error register and raises a one-cycle completion pulse.

An 8-bit mode register controls the rest of the behaviour:
- a CRC enable;
- a 3-bit speed code;
- suppression of frames shorter than four bits;
- a multi-frame option;
- a 2-bit framing select.

In single-frame operation the receiver disarms after one frame. In multi-frame operation at the 212 or 424 kbit/s speed codes, it stays armed and appends a copy of the updated error register to the FIFO after every frame. Multi-frame operation ends when the host issues any command other than Receive, or when the host clears the multi-frame bit.

Top module: `rx_frame_seq`

## Requirements
- R1: The mode register resets to 0x00, loads `mode_wdata` on `mode_wr`, and reads back on `mode_q`. Its fields are bit 7 CRC enable, bits 6:4 speed code (000=106, 001=212, 010=424, 011=848, 100=1696, 101=3392 kbit/s, 110/111 reserved), bit 3 short-frame suppression, bit 2 multi-frame, and bits 1:0 framing (00 type A, 01 active, 10 passive 212/424, 11 type B).
- R2: Command code 0x8 (Receive) arms the receiver. Any other command code disarms it. A frame that is still open when such a command arrives is abandoned: its later bits and end strobe push nothing and raise no completion pulse. A stop command that coincides with the end strobe lets that frame finish.
- R3: Received bits are packed LSB first. The first bit of each byte goes to bit 0. A completed byte appears on `fifo_data` with `fifo_push` high in the cycle after its eighth bit is taken.
- R4: At end-of-frame, a partial last byte is pushed in the following cycle with its unused high bits zero. `last_bits` then gives the number of valid bits in that byte, with 0 meaning all eight.
- R5: The CRC runs serially over every frame bit, LSB first, using the reflected polynomial 0x8408. The seed is 0x6363 for framing 00, 0xFFFF for framing 11 and 0x0000 otherwise. A frame passes when the final register equals 0xF0B8 for framing 11 and 0x0000 otherwise. With CRC enabled, a failure sets error bit 0, and the frame's bytes stay pushed.
- R6: `frame_done` pulses for one cycle, two cycles after the cycle that carries the end strobe. `err_q` takes the frame's result in that same cycle. A start strobe clears `err_q`.
- R7: Error bit 1 is set for a frame received with a reserved speed code, or with CRC disabled at any speed code other than 000.
- R8: With suppression set, a frame of fewer than 4 bits pushes nothing, raises no `frame_done`, leaves `err_q` unchanged and keeps the receiver armed. With suppression clear, such a frame completes normally.
- R9: Without effective multi-frame, the receiver disarms after a completed frame. While disarmed, start strobes, bits and end strobes are ignored.
- R10: Multi-frame is effective only with speed code 001 or 010. When effective, the receiver stays armed after each frame, and the new error register value is pushed to the FIFO in the `frame_done` cycle. At other speeds the multi-frame bit has no effect.
- R11: After the multi-frame bit is cleared, the next completed frame pushes no status byte and disarms the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_wdata | input | 8 | Mode register write value |
| mode_q | output | 8 | Mode register contents |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 4 | Host command code, 0x8 is Receive |
| rx_sof | input | 1 | Start-of-frame strobe |
| rx_bit_valid | input | 1 | A decoded bit is present on rx_bit |
| rx_bit | input | 1 | Decoded bit value |
| rx_eof | input | 1 | End-of-frame strobe, may coincide with the last bit |
| armed | output | 1 | Receiver is armed |
| fifo_push | output | 1 | Push strobe towards the receive FIFO |
| fifo_data | output | 8 | Byte to push |
| last_bits | output | 3 | Valid bits in the last data byte of the frame, 0 means 8 |
| frame_done | output | 1 | One-cycle frame completion pulse |
| err_q | output | 8 | Error register: bit 0 CRC failure, bit 1 configuration error |

## Verification
Two functions can fall in the same cycle: the end of a frame, and a host stop command that ends multi-frame operation. The bench drives a non-Receive command in exactly the cycle that carries the last bit and the end strobe of a multi-frame reception. It then expects the frame to complete in full, with data bytes, CRC bytes, status byte and completion pulse, and the receiver to end up disarmed. A second overlap is a byte that fills in the same cycle as the end strobe. In that case it must be pushed once, as a full byte with `last_bits` at 0. The sweeps over frame length from 1 to 20 bits produce this case.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

    localparam int BYTE_W     = 8;
    localparam int SHORT_BITS = 4;
    localparam int CRC_W      = 16;
    localparam int CMD_W      = 4;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8408;
    localparam logic [CMD_W-1:0] CMD_RECEIVE = 4'h8;

    localparam logic [2:0] SPD_106 = 3'd0;
    localparam logic [2:0] SPD_212 = 3'd1;
    localparam logic [2:0] SPD_424 = 3'd2;
    localparam logic [2:0] SPD_MAX = 3'd5;

    localparam logic [1:0] FRM_A = 2'd0;
    localparam logic [1:0] FRM_B = 2'd3;

    typedef struct packed {
        logic       crc_en;
        logic [2:0] speed;
        logic       drop_short;
        logic       multi;
        logic [1:0] framing;
    } rx_mode_t;

    typedef struct packed {
        logic [5:0] spare;
        logic       cfg_bad;
        logic       crc_fail;
    } rx_err_t;

    function automatic logic multi_active(rx_mode_t m);
        return m.multi && (m.speed == SPD_212 || m.speed == SPD_424);
    endfunction

    function automatic logic cfg_invalid(rx_mode_t m);
        return (m.speed > SPD_MAX) || (!m.crc_en && m.speed != SPD_106);
    endfunction

    function automatic logic [CRC_W-1:0] crc_seed(logic [1:0] fr);
        case (fr)
            FRM_A:   return 16'h6363;
            FRM_B:   return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_good(logic [1:0] fr);
        return (fr == FRM_B) ? 16'hF0B8 : 16'h0000;
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY;
        return n;
    endfunction

endpackage

// File: rtl/rx_bit_packer.sv
module rx_bit_packer #(
    parameter  int WIDTH      = 8,
    parameter  int SHORT_BITS = 4,
    localparam int IW         = $clog2(WIDTH),
    localparam int CW         = IW + 1,
    localparam int TW         = $clog2(SHORT_BITS) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word_o,
    output logic [CW-1:0]    fill_o,
    output logic             short_o
);

    logic [WIDTH-1:0] acc;
    logic [CW-1:0]    cnt;
    logic [TW-1:0]    tot;
    logic [TW-1:0]    tot_next;

    always_comb begin
        word_o = acc;
        if (bit_en) word_o[cnt[IW-1:0]] = bit_in;
        fill_o   = cnt + CW'(bit_en);
        tot_next = tot + TW'(bit_en && (tot < TW'(SHORT_BITS)));
        short_o  = tot_next < TW'(SHORT_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
            cnt <= '0;
            tot <= '0;
        end else if (bit_en) begin
            tot <= tot_next;
            if (fill_o == CW'(WIDTH)) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= word_o;
                cnt <= fill_o;
            end
        end
    end

    a_r3_wrap_clears: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !clear && fill_o == CW'(WIDTH)) |=> (cnt == '0 && acc == '0));

    a_r8_short_bounded: assert property (@(posedge clk) disable iff (rst)
        tot <= TW'(SHORT_BITS));

endmodule

// File: rtl/rx_crc_chk.sv
module rx_crc_chk
    import rx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic [1:0] framing,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       ok_o
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_n;

    always_comb begin
        crc_n = bit_en ? crc_step(crc_q, bit_in) : crc_q;
        ok_o  = (crc_n == crc_good(framing));
    end

    always_ff @(posedge clk) begin
        if (rst)        crc_q <= '0;
        else if (clear) crc_q <= crc_seed(framing);
        else            crc_q <= crc_n;
    end

    a_r5_seeded: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc_q == crc_seed($past(framing))));

endmodule

// File: rtl/rx_arm_ctrl.sv
module rx_arm_ctrl
    import rx_seq_pkg::*;
#(
    parameter  int WIDTH = BYTE_W,
    localparam int IW    = $clog2(WIDTH),
    localparam int CW    = IW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_mode_t         mode_i,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             sof,
    input  logic             bit_valid,
    input  logic             eof,
    input  logic [WIDTH-1:0] word_i,
    input  logic [CW-1:0]    fill_i,
    input  logic             short_i,
    input  logic             crc_ok_i,
    output logic             clear_o,
    output logic             bit_en_o,
    output logic             armed,
    output logic             fifo_push,
    output logic [WIDTH-1:0] fifo_data,
    output logic [IW-1:0]    last_bits,
    output logic             frame_done,
    output logic [7:0]       err_q
);

    logic    in_frame;
    logic    end_pend;
    logic    end_multi;
    logic    end_fail;
    logic    end_cfg;
    logic    go, stop, start, fin, drop;
    rx_err_t err_new;

    always_comb begin
        go       = cmd_valid && (cmd_code == CMD_RECEIVE);
        stop     = cmd_valid && (cmd_code != CMD_RECEIVE);
        start    = armed && sof && !go;
        clear_o  = start || go;
        bit_en_o = armed && in_frame && bit_valid && !sof && !go;
        fin      = armed && in_frame && eof && !sof && !go;
        drop     = fin && short_i && mode_i.drop_short;
        err_new  = '{spare: '0, cfg_bad: end_cfg, crc_fail: end_fail};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            in_frame   <= 1'b0;
            end_pend   <= 1'b0;
            end_multi  <= 1'b0;
            end_fail   <= 1'b0;
            end_cfg    <= 1'b0;
            fifo_push  <= 1'b0;
            fifo_data  <= '0;
            last_bits  <= '0;
            frame_done <= 1'b0;
            err_q      <= '0;
        end else begin
            fifo_push  <= 1'b0;
            frame_done <= 1'b0;

            // full byte in the middle of a frame
            if (bit_en_o && fill_i == CW'(WIDTH) && !fin) begin
                fifo_push <= 1'b1;
                fifo_data <= word_i;
            end

            if (start) begin
                in_frame <= 1'b1;
                err_q    <= '0;
            end

            // end strobe: push the closing byte and latch the frame result
            if (fin) begin
                in_frame <= 1'b0;
                if (!drop) begin
                    end_pend  <= 1'b1;
                    end_multi <= multi_active(mode_i);
                    end_fail  <= mode_i.crc_en && !crc_ok_i;
                    end_cfg   <= cfg_invalid(mode_i);
                    last_bits <= fill_i[IW-1:0];
                    if (fill_i != '0) begin
                        fifo_push <= 1'b1;
                        fifo_data <= word_i;
                    end
                end
            end

            // completion: error register, status byte, arm decision
            if (end_pend) begin
                end_pend   <= 1'b0;
                frame_done <= 1'b1;
                err_q      <= err_new;
                if (end_multi) begin
                    fifo_push <= 1'b1;
                    fifo_data <= WIDTH'(err_new);
                end
                if (!(end_multi && multi_active(mode_i))) armed <= 1'b0;
            end

            if (go) begin
                armed    <= 1'b1;
                in_frame <= 1'b0;
            end else if (stop) begin
                armed    <= 1'b0;
                in_frame <= 1'b0;
            end
        end
    end

    a_r9_single_disarms: assert property (@(posedge clk) disable iff (rst)
        (end_pend && !end_multi && !go) |=> !armed);

    a_r10_status_pushed: assert property (@(posedge clk) disable iff (rst)
        (end_pend && end_multi) |=> fifo_push);

    a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    a_r9_frame_needs_arm: assert property (@(posedge clk) disable iff (rst)
        in_frame |-> armed);

    a_r2_stop_disarms: assert property (@(posedge clk) disable iff (rst)
        stop |=> !armed);

    a_r8_drop_silent: assert property (@(posedge clk) disable iff (rst)
        drop |=> (!fifo_push && !frame_done));

endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
    import rx_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [7:0] mode_wdata,
    output logic [7:0] mode_q,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic       rx_sof,
    input  logic       rx_bit_valid,
    input  logic       rx_bit,
    input  logic       rx_eof,
    output logic       armed,
    output logic       fifo_push,
    output logic [7:0] fifo_data,
    output logic [2:0] last_bits,
    output logic       frame_done,
    output logic [7:0] err_q
);

    localparam int IW = $clog2(BYTE_W);
    localparam int CW = IW + 1;

    rx_mode_t          mode_r;
    logic              clr;
    logic              bit_en;
    logic [BYTE_W-1:0] word;
    logic [CW-1:0]     fill;
    logic              short_f;
    logic              crc_ok;

    always_ff @(posedge clk) begin
        if (rst)          mode_r <= '0;
        else if (mode_wr) mode_r <= rx_mode_t'(mode_wdata);
    end

    assign mode_q = mode_r;

    rx_bit_packer #(.WIDTH(BYTE_W), .SHORT_BITS(SHORT_BITS)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clear   (clr),
        .bit_en  (bit_en),
        .bit_in  (rx_bit),
        .word_o  (word),
        .fill_o  (fill),
        .short_o (short_f)
    );

    rx_crc_chk u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (clr),
        .framing (mode_r.framing),
        .bit_en  (bit_en),
        .bit_in  (rx_bit),
        .ok_o    (crc_ok)
    );

    rx_arm_ctrl #(.WIDTH(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_r),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .sof        (rx_sof),
        .bit_valid  (rx_bit_valid),
        .eof        (rx_eof),
        .word_i     (word),
        .fill_i     (fill),
        .short_i    (short_f),
        .crc_ok_i   (crc_ok),
        .clear_o    (clr),
        .bit_en_o   (bit_en),
        .armed      (armed),
        .fifo_push  (fifo_push),
        .fifo_data  (fifo_data),
        .last_bits  (last_bits),
        .frame_done (frame_done),
        .err_q      (err_q)
    );

    a_r1_mode_load: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == $past(mode_wdata)));

endmodule

// File: tb/test_rx_frame_seq.sv
module test_rx_frame_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_q;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = '0;
    logic       rx_sof = 1'b0;
    logic       rx_bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_eof = 1'b0;
    logic       armed, fifo_push, frame_done;
    logic [7:0] fifo_data, err_q;
    logic [2:0] last_bits;

    always #5 clk = ~clk;

    rx_frame_seq i_rx_frame_seq (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_q(mode_q),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rx_sof(rx_sof),
        .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_eof(rx_eof),
        .armed(armed), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .last_bits(last_bits), .frame_done(frame_done), .err_q(err_q)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    logic [7:0] got_d[$];
    int         got_c[$];
    int         fd_n;
    int         fd_c;

    always @(negedge clk) begin
        if (fifo_push) begin
            got_d.push_back(fifo_data);
            got_c.push_back(cyc);
        end
        if (frame_done) begin
            fd_n = fd_n + 1;
            fd_c = cyc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    bit tx[$];
    int bcyc[$];
    int eofc;

    task automatic set_mode(logic [7:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic command(logic [3:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    // stop_at: bit index on which a non-Receive command is issued, -1 for none
    task automatic drive_frame(int stop_at);
        got_d.delete(); got_c.delete(); bcyc.delete();
        fd_n = 0; fd_c = -1; eofc = -1;
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        if (tx.size() == 0) begin
            rx_eof = 1'b1; eofc = cyc;
            @(negedge clk); rx_eof = 1'b0;
        end else begin
            for (int i = 0; i < tx.size(); i++) begin
                rx_bit_valid = 1'b1;
                rx_bit = tx[i];
                rx_eof = (i == tx.size() - 1);
                bcyc.push_back(cyc);
                if (rx_eof) eofc = cyc;
                if (i == stop_at) begin cmd_valid = 1'b1; cmd_code = 4'h0; end
                @(negedge clk);
                cmd_valid = 1'b0;
            end
            rx_bit_valid = 1'b0; rx_eof = 1'b0;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic make_bits(int n, int seed);
        tx.delete();
        for (int i = 0; i < n; i++) tx.push_back(bit'(((i * 7 + seed * 3) % 5) < 2));
    endtask

    task automatic make_crc_frame(int nbytes, int fr, bit corrupt, int seed);
        logic [15:0] c;
        logic [7:0]  b;
        bit          fb;
        tx.delete();
        for (int j = 0; j < nbytes; j++) begin
            b = 8'((seed * 37 + j * 91 + 5) & 255);
            for (int k = 0; k < 8; k++) tx.push_back(b[k]);
        end
        c = (fr == 0) ? 16'h6363 : (fr == 3) ? 16'hFFFF : 16'h0000;
        foreach (tx[i]) begin
            fb = c[0] ^ tx[i];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
        end
        if (fr == 3) c = ~c;
        for (int k = 0; k < 16; k++) tx.push_back(c[k]);
        if (corrupt) tx[0] = ~tx[0];
    endtask

    task automatic expect_frame(string req, bit drop, bit stat, int err_exp, bit arm_exp);
        int nb;
        logic [7:0] e;
        nb = (tx.size() + 7) / 8;
        if (drop) begin
            chk(req, "pushes on dropped frame", got_d.size(), 0);
            chk(req, "done on dropped frame", fd_n, 0);
        end else begin
            chk(req, "push count", got_d.size(), nb + int'(stat));
            for (int j = 0; j < nb && j < got_d.size(); j++) begin
                e = '0;
                for (int k = 0; k < 8; k++)
                    if (j * 8 + k < tx.size()) e[k] = tx[j * 8 + k];
                chk(req, $sformatf("byte %0d", j), got_d[j], e);
                chk(req, $sformatf("byte %0d cycle", j), got_c[j],
                    bcyc[(j * 8 + 7 < tx.size()) ? j * 8 + 7 : tx.size() - 1] + 1);
            end
            if (nb > 0) chk("R4", "last_bits", last_bits, tx.size() % 8);
            chk("R6", "done count", fd_n, 1);
            chk("R6", "done cycle", fd_c, eofc + 2);
            chk(req, "err_q", err_q, err_exp);
            if (stat && got_d.size() == nb + 1) begin
                chk("R10", "status byte", got_d[nb], err_exp);
                chk("R10", "status cycle", got_c[nb], eofc + 2);
            end
        end
        chk(req, "armed after frame", armed, arm_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset mode", mode_q, 8'h00);
        chk("R2", "reset armed", armed, 0);
        chk("R6", "reset err", err_q, 0);
        chk("R3", "reset push", fifo_push, 0);

        // R9: disarmed receiver ignores a frame
        make_bits(10, 1);
        drive_frame(-1);
        chk("R9", "pushes while disarmed", got_d.size(), 0);
        chk("R9", "done while disarmed", fd_n, 0);

        set_mode(8'hA5);
        chk("R1", "mode readback", mode_q, 8'hA5);
        set_mode(8'h00);
        chk("R1", "mode cleared", mode_q, 8'h00);

        // R3/R4/R9: packing sweep over frame lengths, single frame
        for (int n = 1; n <= 20; n++) begin
            command(4'h8);
            make_bits(n, n);
            drive_frame(-1);
            expect_frame("R3", 1'b0, 1'b0, 0, 1'b0);
        end

        // R8: short frames with and without suppression
        set_mode(8'h08);
        for (int n = 0; n <= 5; n++) begin
            command(4'h8);
            make_bits(n, n + 2);
            drive_frame(-1);
            expect_frame("R8", n < 4, 1'b0, 0, n < 4);
        end
        command(4'h0);
        set_mode(8'h00);
        for (int n = 0; n <= 3; n++) begin
            command(4'h8);
            make_bits(n, n + 4);
            drive_frame(-1);
            expect_frame("R8", 1'b0, 1'b0, 0, 1'b0);
        end

        // R5: CRC over all framings, lengths, good and corrupted
        for (int fr = 0; fr < 4; fr++) begin
            set_mode((fr == 0) ? 8'h80 : (8'hA0 | 8'(fr)));
            for (int nb = 1; nb <= 3; nb++) begin
                for (int bad = 0; bad < 2; bad++) begin
                    command(4'h8);
                    make_crc_frame(nb, fr, bit'(bad), fr * 5 + nb);
                    drive_frame(-1);
                    expect_frame("R5", 1'b0, 1'b0, bad, 1'b0);
                end
            end
        end

        // R7: configuration errors
        set_mode(8'hE0);
        command(4'h8); make_crc_frame(2, 0, 1'b0, 9); drive_frame(-1);
        expect_frame("R7", 1'b0, 1'b0, 2, 1'b0);
        set_mode(8'h10);
        command(4'h8); make_crc_frame(2, 0, 1'b0, 10); drive_frame(-1);
        expect_frame("R7", 1'b0, 1'b0, 2, 1'b0);

        // R10: multi-frame at 212 kbit/s
        set_mode(8'h96);
        command(4'h8);
        for (int f = 0; f < 3; f++) begin
            make_crc_frame(f + 1, 2, 1'b0, 20 + f);
            drive_frame(-1);
            expect_frame("R10", 1'b0, 1'b1, 0, 1'b1);
        end
        make_crc_frame(2, 2, 1'b1, 30);
        drive_frame(-1);
        expect_frame("R10", 1'b0, 1'b1, 1, 1'b1);
        // R2/R11 collision: stop command in the end-strobe cycle
        make_crc_frame(2, 2, 1'b0, 31);
        drive_frame(tx.size() - 1);
        expect_frame("R2", 1'b0, 1'b1, 0, 1'b0);

        // R10: multi-frame bit has no effect at 848 kbit/s
        set_mode(8'hB6);
        command(4'h8); make_crc_frame(1, 2, 1'b0, 32); drive_frame(-1);
        expect_frame("R10", 1'b0, 1'b0, 0, 1'b0);

        // R11: clearing the multi-frame bit ends multi-frame operation
        set_mode(8'hA6);
        command(4'h8); make_crc_frame(1, 2, 1'b0, 33); drive_frame(-1);
        expect_frame("R11", 1'b0, 1'b1, 0, 1'b1);
        set_mode(8'hA2);
        make_crc_frame(1, 2, 1'b0, 34); drive_frame(-1);
        expect_frame("R11", 1'b0, 1'b0, 0, 1'b0);

        // R2: stop command abandons an open frame
        set_mode(8'h00);
        command(4'h8);
        make_bits(12, 3);
        drive_frame(5);
        chk("R2", "pushes after abort", got_d.size(), 0);
        chk("R2", "done after abort", fd_n, 0);
        chk("R2", "armed after abort", armed, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule